// File: doc/BRIEF.md
# Write-Increment Monotonic Counter

This block keeps a 64-bit count that software sees as two 32-bit halves, low and high. A mode bit sets what a data write does. With the bit clear, a write stores its data into the selected half. This is how the count is seeded, and how an overflow is recovered from. With the bit set, a write to the low half is only an increment command. The whole 64-bit value advances by one, and the data that came with the write is thrown away.

When an increment wraps the full 64-bit value, a sticky overflow flag is raised. While the flag is up, increments are ignored and both halves read back as zero. The only way to clear the flag is to write the high half with the mode bit clear.

A write and a mode-bit update may arrive in the same cycle. In that case the write is handled under the mode that held before that clock edge.

Top module: `mono_ctr`

## Requirements
- R1: After reset both halves read 0, the mode bit reads 0 and the overflow flag is 0.
- R2: In load mode (mode bit 0), a write with `wr_sel`=0 stores `wr_data` into the low half and leaves the high half unchanged.
- R3: In load mode, a write with `wr_sel`=1 stores `wr_data` into the high half and leaves the low half unchanged.
- R4: In increment mode (mode bit 1), a write with `wr_sel`=0 adds one to the 64-bit value {high, low} and ignores `wr_data`.
- R5: An increment that carries out of the low half also adds one to the high half.
- R6: In increment mode, a write with `wr_sel`=1 changes neither half.
- R7: An increment when both halves are all ones sets the overflow flag. Both halves then read 0.
- R8: While the overflow flag is set, increment writes change nothing. The flag stays set and the stored value stays where the wrap left it (zero).
- R9: A load-mode write to the high half clears the overflow flag. A write to the high half in increment mode does not clear it.
- R10: A data write in the same cycle as a mode-bit update is handled under the mode value from before that edge.
- R11: With no write, both halves hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Updates the mode bit |
| cfg_mode | input | 1 | New mode bit value (1 = increment mode) |
| wr_en | input | 1 | Data write strobe |
| wr_sel | input | 1 | Target half: 0 low, 1 high |
| wr_data | input | 32 | Write data |
| lo_q | output | 32 | Low half read-back (zero while overflow is set) |
| hi_q | output | 32 | High half read-back (zero while overflow is set) |
| mode_q | output | 1 | Current mode bit |
| ovf_q | output | 1 | Sticky overflow flag |

## Verification
Some rules are checked by assertions on every cycle:
- the one-step advance of an increment, including the carry;
- the immunity of both halves to high-half writes in increment mode;
- the stickiness of the flag;
- that the flag is cleared only by a load-mode high write;
- that the value holds on idle cycles.

Other behaviour can only be shown by the bench's directed scenarios, which check exact values at the ports:
- the full wrap at all ones;
- that increments made during overflow are discarded, seen after the flag is cleared;
- the old-mode rule when a write and a mode update fall in the same cycle.

// File: rtl/mono_ctr.sv
module mono_ctr #(
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_mode,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [HALF_W-1:0] wr_data,
  output logic [HALF_W-1:0] lo_q,
  output logic [HALF_W-1:0] hi_q,
  output logic              mode_q,
  output logic              ovf_q
);
  localparam int CNT_W = 2 * HALF_W;

  logic [HALF_W-1:0] lo_r, hi_r;
  logic              mode_r, ovf_r;
  logic [CNT_W:0]    sum;

  wire do_inc   = wr_en && !wr_sel && mode_r && !ovf_r;
  wire do_ld_lo = wr_en && !wr_sel && !mode_r;
  wire do_ld_hi = wr_en &&  wr_sel && !mode_r;

  assign sum = {1'b0, hi_r, lo_r} + (CNT_W+1)'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_r   <= '0;
      hi_r   <= '0;
      mode_r <= 1'b0;
      ovf_r  <= 1'b0;
    end else begin
      if (cfg_we) mode_r <= cfg_mode;
      if (do_inc) begin
        {hi_r, lo_r} <= sum[CNT_W-1:0];
        if (sum[CNT_W]) ovf_r <= 1'b1;
      end
      if (do_ld_lo) lo_r <= wr_data;
      if (do_ld_hi) begin
        hi_r  <= wr_data;
        ovf_r <= 1'b0;
      end
    end
  end

  assign lo_q   = ovf_r ? '0 : lo_r;
  assign hi_q   = ovf_r ? '0 : hi_r;
  assign mode_q = mode_r;
  assign ovf_q  = ovf_r;

  // R4 R5
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && mode_q && !ovf_q && !(&{hi_q, lo_q}))
      |=> ({hi_q, lo_q} == $past({hi_q, lo_q}) + CNT_W'(1)));

  // R6
  hi_inc_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel && mode_q) |=> ($stable(hi_q) && $stable(lo_q) && $stable(ovf_q)));

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !(wr_en && wr_sel && !mode_q)) |=> ovf_q);

  // R9
  ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel && !mode_q) |=> (!ovf_q && hi_q == $past(wr_data)));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(lo_q) && $stable(hi_q) && $stable(ovf_q)));
endmodule

// File: tb/mono_ctr_tb.sv
module mono_ctr_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_mode = 1'b0;
  logic        wr_en = 1'b0, wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] lo_q, hi_q;
  logic        mode_q, ovf_q;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  mono_ctr u_dut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .lo_q(lo_q), .hi_q(hi_q), .mode_q(mode_q), .ovf_q(ovf_q));

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cyc(bit we, bit sel, logic [31:0] d, bit cw, bit cm);
    @(negedge clk);
    wr_en = we; wr_sel = sel; wr_data = d; cfg_we = cw; cfg_mode = cm;
    @(negedge clk);
    wr_en = 0; cfg_we = 0;
  endtask

  task automatic wr(bit sel, logic [31:0] d);  cyc(1, sel, d, 0, 0); endtask
  task automatic mode(bit m);                  cyc(0, 0, '0, 1, m); endtask

  task automatic t_reset;
    chk("R1 value", {hi_q, lo_q}, 64'd0);
    chk("R1 flags", {62'd0, mode_q, ovf_q}, 64'd0);
  endtask

  task automatic t_load;
    wr(0, 32'h1234_5678);
    chk("R2 low load", {hi_q, lo_q}, 64'h0000_0000_1234_5678);
    wr(1, 32'h0000_AABB);
    chk("R3 high load", {hi_q, lo_q}, 64'h0000_AABB_1234_5678);
  endtask

  task automatic t_inc;
    mode(1);
    chk("R4 mode bit", {63'd0, mode_q}, 64'd1);
    wr(0, 32'hDEAD_BEEF);
    chk("R4 increment", {hi_q, lo_q}, 64'h0000_AABB_1234_5679);
    mode(0); wr(0, 32'hFFFF_FFFF); wr(1, 32'd5); mode(1);
    wr(0, 32'h0);
    chk("R5 carry", {hi_q, lo_q}, 64'h0000_0006_0000_0000);
    wr(1, 32'h77);
    chk("R6 high ignored", {hi_q, lo_q}, 64'h0000_0006_0000_0000);
    repeat (3) @(negedge clk);
    chk("R11 idle hold", {hi_q, lo_q}, 64'h0000_0006_0000_0000);
  endtask

  task automatic t_ovf;
    mode(0); wr(0, 32'hFFFF_FFFF); wr(1, 32'hFFFF_FFFF); mode(1);
    chk("R7 before wrap", {hi_q, lo_q}, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(0, 32'h1);
    chk("R7 flag", {63'd0, ovf_q}, 64'd1);
    chk("R7 reads zero", {hi_q, lo_q}, 64'd0);
    for (int i = 0; i < 3; i++) wr(0, 32'h9);
    chk("R8 flag held", {63'd0, ovf_q}, 64'd1);
    wr(1, 32'h33);
    chk("R9 inc-mode high keeps flag", {63'd0, ovf_q}, 64'd1);
    mode(0);
    wr(1, 32'h42);
    chk("R9 flag cleared", {63'd0, ovf_q}, 64'd0);
    chk("R8 increments discarded", {hi_q, lo_q}, 64'h0000_0042_0000_0000);
  endtask

  task automatic t_same_cycle;
    cyc(1, 0, 32'h55, 1, 1);
    chk("R10 load under old mode", {hi_q, lo_q}, 64'h0000_0042_0000_0055);
    chk("R10 mode now set", {63'd0, mode_q}, 64'd1);
    cyc(1, 0, 32'h99, 1, 0);
    chk("R10 inc under old mode", {hi_q, lo_q}, 64'h0000_0042_0000_0056);
    chk("R10 mode now clear", {63'd0, mode_q}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_inc();
    t_ovf();
    t_same_cycle();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule